// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block is the interrupt front end of a sixteen-line GPIO port expander. Every input pin is brought into the clock domain through a two-stage synchroniser. A third sample of each line is kept so that transitions can be seen. A per-line two-bit sense code picks which transitions count: rising, falling, both or none. A qualifying transition sets that line's pending bit, and the pending bit stays set until software clears it.

A single active-low request line goes low while at least one pending line is also unmasked. Software reaches the block through a byte-wide register port with an address, write data, a write strobe, a read strobe and combinational read data. Pending bits are cleared by writing ones to the source register. Depending on a configuration bit, they can also be cleared by reading the pin data register. The sense, mask and source registers of the host-side driver map onto this port directly.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, irqN is high, both mask bytes (addresses 2 and 3) read 0xFF, both source bytes (4 and 5) read 0x00, all four sense bytes (6 to 9) read 0x00 and the config byte (10) reads 0x00.
- R2: Sense code 01 in the two-bit field at bit 2×line of the 32-bit sense value sets the pending bit on a low-to-high transition only.
- R3: Sense code 10 sets the pending bit on a high-to-low transition only.
- R4: Sense code 11 sets the pending bit on both kinds of transition.
- R5: Sense code 00 never sets the pending bit, whatever the pin does.
- R6: Pending bits latch whether or not the line is masked (mask bit 1 = masked). irqN is low exactly while some pending bit has its mask bit at 0, so unmasking an already pending line pulls irqN low.
- R7: Writing a 1 to a source bit clears it, and writing a 0 leaves it unchanged. Source byte 4 holds lines 15..8 and byte 5 holds lines 7..0. Mask bytes 2 and 3 and data bytes 0 and 1 use the same byte split.
- R8: When a qualifying transition and a clearing write to the same bit fall in the same cycle, the bit stays set.
- R9: With config bit 0 (address 10) at 0, a read strobe on either data byte clears every pending bit. With it at 1, such reads leave the pending bits alone.
- R10: Data bytes 0 and 1 return the synchronised pin levels, which reflect a pin change two clock edges after it is applied.
- R11: A qualifying pin change on an unmasked line drives irqN low at the third clock edge after the change, and not earlier.
- R12: The 32-bit sense value is stored most significant byte first: address 6 holds lines 15..12 and address 9 holds lines 3..0, with the lowest line of each byte in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 8 | Register write data |
| regWe | input | 1 | Write strobe, one cycle per byte written |
| regRe | input | 1 | Read strobe, used by the read-clear option |
| regRdata | output | 8 | Combinational read data for regAddr |
| pinIn | input | 16 | Asynchronous GPIO pin levels |
| irqN | output | 1 | Interrupt request, active low |

## Verification
A pin change applied at a falling clock edge reaches the data register after two rising edges. It reaches the pending bit, and therefore irqN, after three. The bench samples at the falling edge after the second rising edge to confirm that irqN is still high, and again after the third to confirm that it has dropped. Register writes take effect at the single rising edge that the strobe spans, and reads are combinational, so every read-back is sampled one falling edge after the write. The same-cycle collision is staged by raising the clear strobe in exactly the cycle between the second and third rising edges after a pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // width of the byte index carried by the decode strobe
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_DATA,
    RK_MASK,
    RK_SRC,
    RK_SENSE,
    RK_CFG
  } regKind_e;

  // one register access, as decoded by the control module
  typedef struct packed {
    regKind_e         kind;
    logic [IDX_W-1:0] idx;   // byte offset within the register, 0 = most significant
    logic             wr;
    logic             rd;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SNS_OFF  = 2'b00,
    SNS_RISE = 2'b01,
    SNS_FALL = 2'b10,
    SNS_BOTH = 2'b11
  } sense_e;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  output regStrobe_t        strb
);

  localparam int LINE_BYTES  = (LINES + 7) / 8;
  localparam int SENSE_BYTES = (2 * LINES + 7) / 8;
  localparam int MASK_BASE   = LINE_BYTES;
  localparam int SRC_BASE    = 2 * LINE_BYTES;
  localparam int SENSE_BASE  = 3 * LINE_BYTES;
  localparam int CFG_ADDR    = SENSE_BASE + SENSE_BYTES;

  // address ranges in ascending order: data, mask, source, sense, config
  always_comb begin
    strb      = '0;
    strb.kind = RK_NONE;
    if (regAddr < ADDR_W'(MASK_BASE)) begin
      strb.kind = RK_DATA;
      strb.idx  = IDX_W'(regAddr);
    end else if (regAddr < ADDR_W'(SRC_BASE)) begin
      strb.kind = RK_MASK;
      strb.idx  = IDX_W'(regAddr - ADDR_W'(MASK_BASE));
    end else if (regAddr < ADDR_W'(SENSE_BASE)) begin
      strb.kind = RK_SRC;
      strb.idx  = IDX_W'(regAddr - ADDR_W'(SRC_BASE));
    end else if (regAddr < ADDR_W'(CFG_ADDR)) begin
      strb.kind = RK_SENSE;
      strb.idx  = IDX_W'(regAddr - ADDR_W'(SENSE_BASE));
    end else if (regAddr == ADDR_W'(CFG_ADDR)) begin
      strb.kind = RK_CFG;
    end
    strb.wr = regWe && (strb.kind != RK_NONE);
    strb.rd = regRe && (strb.kind != RK_NONE);
  end

endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [1:0] sense,
  output logic       syncVal,
  output logic       edgeHit
);

  // [0] first sync stage, [1] second sync stage, [2] previous sample
  logic [2:0] sampQ;
  logic       rising;
  logic       falling;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampQ <= '0;
    else       sampQ <= {sampQ[1:0], pinIn};
  end

  assign rising  = sampQ[1] & ~sampQ[2];
  assign falling = ~sampQ[1] & sampQ[2];
  assign syncVal = sampQ[1];

  always_comb begin
    unique case (sense_e'(sense))
      SNS_RISE: edgeHit = rising;
      SNS_FALL: edgeHit = falling;
      SNS_BOTH: edgeHit = rising | falling;
      default:  edgeHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pinIn,
  input  regStrobe_t       strb,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             irqN,
  output logic [LINES-1:0] pendOut,
  output logic [LINES-1:0] maskOut,
  output logic [LINES-1:0] hitOut
);

  localparam int LINE_BYTES  = (LINES + 7) / 8;
  localparam int SENSE_BYTES = (2 * LINES + 7) / 8;
  localparam int LW          = LINE_BYTES * 8;
  localparam int SW          = SENSE_BYTES * 8;

  logic [LW-1:0] maskQ, maskD;
  logic [LW-1:0] pendQ, pendD;
  logic [SW-1:0] senseQ, senseD;
  logic          cfgQ, cfgD;
  logic [LW-1:0] clrVec;
  logic [LW-1:0] hitVec;
  logic [LW-1:0] syncVec;
  logic [LINES-1:0] laneHit;
  logic [LINES-1:0] laneSync;
  logic          readClear;

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    gpio_irq_lane u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinIn[i]),
      .sense  (senseQ[2*i +: 2]),
      .syncVal(laneSync[i]),
      .edgeHit(laneHit[i])
    );
  end

  assign hitVec  = LW'(laneHit);
  assign syncVec = LW'(laneSync);

  // a read strobe on the data register clears all sources unless disabled
  assign readClear = strb.rd && (strb.kind == RK_DATA) && !cfgQ;

  always_comb begin
    maskD  = maskQ;
    senseD = senseQ;
    cfgD   = cfgQ;
    clrVec = '0;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (int'(strb.idx) == LINE_BYTES - 1 - b) begin
        if (strb.wr && strb.kind == RK_MASK) maskD[b*8 +: 8] = regWdata;
        if (strb.wr && strb.kind == RK_SRC)  clrVec[b*8 +: 8] = regWdata;
      end
    end
    for (int b = 0; b < SENSE_BYTES; b++) begin
      if (strb.wr && strb.kind == RK_SENSE && int'(strb.idx) == SENSE_BYTES - 1 - b)
        senseD[b*8 +: 8] = regWdata;
    end
    if (strb.wr && strb.kind == RK_CFG) cfgD = regWdata[0];
    if (readClear) clrVec = '1;
    // a new edge takes precedence over a clear in the same cycle
    pendD = (pendQ & ~clrVec) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      pendQ  <= '0;
      senseQ <= '0;
      cfgQ   <= 1'b0;
    end else begin
      maskQ  <= maskD;
      pendQ  <= pendD;
      senseQ <= senseD;
      cfgQ   <= cfgD;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (int'(strb.idx) == LINE_BYTES - 1 - b) begin
        if (strb.kind == RK_DATA) regRdata = syncVec[b*8 +: 8];
        if (strb.kind == RK_MASK) regRdata = maskQ[b*8 +: 8];
        if (strb.kind == RK_SRC)  regRdata = pendQ[b*8 +: 8];
      end
    end
    for (int b = 0; b < SENSE_BYTES; b++) begin
      if (strb.kind == RK_SENSE && int'(strb.idx) == SENSE_BYTES - 1 - b)
        regRdata = senseQ[b*8 +: 8];
    end
    if (strb.kind == RK_CFG) regRdata = {7'b0, cfgQ};
  end

  assign irqN    = ~|(pendQ & ~maskQ);
  assign pendOut = pendQ[LINES-1:0];
  assign maskOut = maskQ[LINES-1:0];
  assign hitOut  = laneHit;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  logic              regWe,
  input  logic              regRe,
  output logic [7:0]        regRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic              irqN
);

  regStrobe_t       strb;
  logic [LINES-1:0] pendQ;
  logic [LINES-1:0] maskQ;
  logic [LINES-1:0] edgeHit;

  gpio_irq_ctrl #(
    .LINES (LINES),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .regRe  (regRe),
    .strb   (strb)
  );

  gpio_irq_datapath #(
    .LINES(LINES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strb    (strb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irqN    (irqN),
    .pendOut (pendQ),
    .maskOut (maskQ),
    .hitOut  (edgeHit)
  );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int LINES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic             regRe,
  input logic             irqN,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] edgeHit
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // R2: a source bit only rises after its lane reported a qualifying edge
    assert_set_by_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pend[i]) |-> $past(edgeHit[i]));
    // R8: an edge always lands in the source register, even against a clear
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> pend[i]);
    // R7: a source bit only drops after a register access
    assert_clear_by_access_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pend[i]) |-> $past(regWe || regRe));
  end

  // R6: nothing pending means no request
  assert_idle_when_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pend == '0) |-> irqN);
  // R1: with every line masked (the reset state) no request is raised
  assert_idle_when_masked_R1: assert property (@(posedge clk) disable iff (!rstN)
    (&mask) |-> irqN);

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.LINES(LINES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .regWe  (regWe),
  .regRe  (regRe),
  .irqN   (irqN),
  .pend   (pendQ),
  .mask   (maskQ),
  .edgeHit(edgeHit)
);

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [7:0]  regRdata;
  logic [15:0] pinIn = '0;
  logic        irqN;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata), .pinIn(pinIn), .irqN(irqN)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, input logic re, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRe = re;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  // apply a pin pattern and wait until a resulting edge has been latched
  task automatic setPins(input logic [15:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 irqN", 16'(irqN), 16'h1);
    rdReg(8'd2, 1'b0, rv); check("R1 mask hi", 16'(rv), 16'hff);
    rdReg(8'd3, 1'b0, rv); check("R1 mask lo", 16'(rv), 16'hff);
    rdReg(8'd4, 1'b0, rv); check("R1 src hi", 16'(rv), 16'h00);
    rdReg(8'd5, 1'b0, rv); check("R1 src lo", 16'(rv), 16'h00);
    for (int a = 6; a < 10; a++) begin
      rdReg(8'(a), 1'b0, rv); check("R1 sense", 16'(rv), 16'h00);
    end
    rdReg(8'd10, 1'b0, rv); check("R1 cfg", 16'(rv), 16'h00);
  endtask

  task automatic t_rise;
    wrReg(8'd10, 8'h01);           // keep pending bits on data reads
    wrReg(8'd9, 8'h01);            // line 0 rising
    wrReg(8'd3, 8'hfe);            // unmask line 0
    @(negedge clk); pinIn[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); check("R11 irqN not yet", 16'(irqN), 16'h1);
    @(posedge clk);
    @(negedge clk); check("R11 irqN due", 16'(irqN), 16'h0);
    rdReg(8'd5, 1'b0, rv); check("R2 rise latched", 16'(rv), 16'h01);
    wrReg(8'd5, 8'h01);
    rdReg(8'd5, 1'b0, rv); check("R7 clear by one", 16'(rv), 16'h00);
    check("R7 irqN released", 16'(irqN), 16'h1);
    setPins(pinIn & ~16'h0001);
    rdReg(8'd5, 1'b0, rv); check("R2 fall ignored", 16'(rv), 16'h00);
  endtask

  task automatic t_fall;
    wrReg(8'd8, 8'h08);            // line 5 falling
    wrReg(8'd3, 8'hdf);
    setPins(pinIn | 16'h0020);
    rdReg(8'd5, 1'b0, rv); check("R3 rise ignored", 16'(rv), 16'h00);
    setPins(pinIn & ~16'h0020);
    rdReg(8'd5, 1'b0, rv); check("R3 fall latched", 16'(rv), 16'h20);
    check("R3 irqN", 16'(irqN), 16'h0);
    wrReg(8'd5, 8'h20);
  endtask

  task automatic t_both;
    wrReg(8'd6, 8'h30);            // line 14 both edges, top sense byte
    setPins(pinIn | 16'h4000);
    rdReg(8'd4, 1'b0, rv); check("R4 R12 rise", 16'(rv), 16'h40);
    wrReg(8'd4, 8'h40);
    setPins(pinIn & ~16'h4000);
    rdReg(8'd4, 1'b0, rv); check("R4 fall", 16'(rv), 16'h40);
    wrReg(8'd4, 8'h40);
    rdReg(8'd6, 1'b0, rv); check("R12 sense readback", 16'(rv), 16'h30);
  endtask

  task automatic t_off;
    setPins(pinIn | 16'h0200);     // line 9 keeps code 00
    setPins(pinIn & ~16'h0200);
    rdReg(8'd4, 1'b0, rv); check("R5 no detect", 16'(rv), 16'h00);
  endtask

  task automatic t_mask;
    setPins(pinIn | 16'h4000);     // line 14 masked (addr 2 still 0xff)
    rdReg(8'd4, 1'b0, rv); check("R6 latched while masked", 16'(rv), 16'h40);
    check("R6 irqN masked", 16'(irqN), 16'h1);
    wrReg(8'd2, 8'hbf);
    check("R6 irqN on unmask", 16'(irqN), 16'h0);
  endtask

  task automatic t_clr0;
    wrReg(8'd4, 8'h00);
    rdReg(8'd4, 1'b0, rv); check("R7 zero write", 16'(rv), 16'h40);
    wrReg(8'd4, 8'hbf);
    rdReg(8'd4, 1'b0, rv); check("R7 other bits", 16'(rv), 16'h40);
  endtask

  task automatic t_collide;
    @(negedge clk); pinIn[14] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);                // edge is visible this cycle
    regAddr = 8'd4; regWdata = 8'h40; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
    rdReg(8'd4, 1'b0, rv); check("R8 edge beats clear", 16'(rv), 16'h40);
    wrReg(8'd4, 8'h40);
    rdReg(8'd4, 1'b0, rv); check("R8 later clear", 16'(rv), 16'h00);
    check("R8 irqN", 16'(irqN), 16'h1);
  endtask

  task automatic t_autoclr;
    setPins(pinIn | 16'h0001);     // line 0 rising, cfg bit = 1
    rdReg(8'd1, 1'b1, rv); check("R10 data lo", 16'(rv), 16'h01);
    rdReg(8'd5, 1'b0, rv); check("R9 kept when off", 16'(rv), 16'h01);
    wrReg(8'd10, 8'h00);
    rdReg(8'd0, 1'b1, rv);
    rdReg(8'd5, 1'b0, rv); check("R9 cleared by read", 16'(rv), 16'h00);
    check("R9 irqN", 16'(irqN), 16'h1);
  endtask

  task automatic t_data;
    logic [15:0] old;
    old = pinIn;
    @(negedge clk); pinIn = 16'ha5c3;
    regAddr = 8'd0;
    @(posedge clk);
    @(negedge clk); #1 check("R10 not yet", 16'(regRdata), 16'(old[15:8]));
    @(posedge clk);
    @(negedge clk); #1 check("R10 hi", 16'(regRdata), 16'ha5);
    regAddr = 8'd1; #1 check("R10 lo", 16'(regRdata), 16'hc3);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset;
    t_rise;
    t_fall;
    t_both;
    t_off;
    t_mask;
    t_clr0;
    t_collide;
    t_autoclr;
    t_data;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule